// File: doc/BRIEF.md
# PCI Target Window Decoder and Address Translator

This block sits behind the pins of a 32-bit PCI target. When the bus logic has caught an address phase, the block decides whether the access belongs to this device. It compares the address against six independently enabled windows. Each window has a base, a size mask and a translation base. The lowest-numbered matching window wins. On a hit, the upper address bits covered by the mask are replaced with the window's translation base, and the result is handed to the internal bus as a privileged request.

Only single-address memory commands are claimed. The device-select indication follows medium decode timing. A claimed write forwards its data and byte enables. A claimed write with no byte lane enabled still completes on the PCI side, but no internal write is issued. A claimed read always returns a full 32-bit word from the internal side, whatever lanes are enabled, and this includes a read with no lanes enabled.

Top module: `pci_win_xlate`

## Requirements
- R1: Window i hits when win_en[i] is 1 and (ap_addr & mask_i) == (base_i & mask_i). Windows are packed in the flat vectors as slice i = bits [32*i+31 : 32*i]. An address phase that hits no enabled window is not claimed: devsel, req_valid and trdy stay 0.
- R2: When win_en is all zeros, no address phase is claimed, whatever its address or command.
- R3: Only the memory commands 4'h6 (read), 4'h7 (write), 4'hC (read multiple), 4'hE (read line) and 4'hF (write and invalidate) can be claimed. I/O (4'h2, 4'h3), configuration (4'hA, 4'hB) and dual address cycle (4'hD) phases are never claimed.
- R4: Suppose frame_start is 1 at rising edge n and the phase is claimed. Then devsel is 1 only in the cycle between edges n+1 and n+2. It is 0 in the cycle after edge n.
- R5: The request address is (xlat_i & mask_i) | (ap_addr & ~mask_i), where i is the selected window.
- R6: When several enabled windows match, the window with the lowest index is used.
- R7: A request is presented with req_valid in the same cycle as devsel. It carries req_priv = 1, req_write = ap_cmd[0], and the captured byte enables (active high, bit k = byte lane k) and write data.
- R8: A claimed write with ap_be == 0 asserts devsel and later trdy, but never asserts req_valid, so internal memory is unchanged.
- R9: A claimed read with ap_be == 0 still issues an internal read and completes with trdy and the full 32-bit word.
- R10: For a claimed read, the cycle after the edge that samples rsp_valid shows trdy = 1, and pci_rdata equals the full rsp_data word. For a claimed write, trdy is 1 in the cycle after devsel.
- R11: While rst is high at a rising edge, devsel, req_valid, req_priv and trdy are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | High for the one cycle in which the address-phase bundle is valid |
| ap_addr | input | AW | Captured PCI address |
| ap_cmd | input | 4 | Captured bus command |
| ap_be | input | DW/8 | Byte enables, active high |
| ap_wdata | input | DW | Write data for the single data phase |
| win_en | input | NWIN | Per-window enable |
| win_base | input | NWIN*AW | Window base addresses, slice i for window i |
| win_mask | input | NWIN*AW | Window size masks (1 = bit compared and replaced) |
| win_xlat | input | NWIN*AW | Window translation bases |
| devsel | output | 1 | Device select, medium timing |
| req_valid | output | 1 | Internal request strobe |
| req_addr | output | AW | Translated internal address |
| req_write | output | 1 | Internal request is a write |
| req_priv | output | 1 | Internal request is privileged |
| req_be | output | DW/8 | Internal request byte enables |
| req_wdata | output | DW | Internal write data |
| rsp_valid | input | 1 | Internal read data valid |
| rsp_data | input | DW | Internal read data |
| trdy | output | 1 | Data phase completes on PCI |
| pci_rdata | output | DW | Read data toward PCI, all four lanes |

## Verification
The window set is built so that two windows overlap. An address inside both shows whether the lower index wins. An address inside only the larger window shows that the mask, and not the order, decides the match. A third window has a translation base with low bits set, which shows that those bits are masked off. A disabled window and a plain miss separate the enable check from the compare. The same hitting address is sent with I/O, configuration and dual-address commands, and with every enable cleared, to show that claiming depends on the command and on the enables. Writes with partial and empty lane masks are read back through the bench memory. This tells a merged write from a dropped write, and it shows that a read with no enabled lanes still returns the whole word.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

  typedef enum logic [3:0] {
    CMD_IO_RD   = 4'h2,
    CMD_IO_WR   = 4'h3,
    CMD_MEM_RD  = 4'h6,
    CMD_MEM_WR  = 4'h7,
    CMD_CFG_RD  = 4'hA,
    CMD_CFG_WR  = 4'hB,
    CMD_MEM_RDM = 4'hC,
    CMD_DUAL    = 4'hD,
    CMD_MEM_RDL = 4'hE,
    CMD_MEM_WRI = 4'hF
  } pci_cmd_e;

  // Single-address memory commands are the only ones this target answers.
  function automatic logic cmd_is_mem(input logic [3:0] c);
    logic r;
    case (c)
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM, CMD_MEM_RDL, CMD_MEM_WRI: r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic cmd_is_wr(input logic [3:0] c);
    return c[0];
  endfunction

endpackage

// File: rtl/pwx_win_cmp.sv
module pwx_win_cmp #(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] xlat,
  output logic          hit,
  output logic [AW-1:0] xaddr
);
  always_comb begin
    hit   = en && ((addr & mask) == (base & mask));
    xaddr = (xlat & mask) | (addr & ~mask);
  end
endmodule

// File: rtl/pwx_prio_pick.sv
module pwx_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] hit,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwx_rsp_path.sv
module pwx_rsp_path #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_vld,
  input  logic          start_wr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          trdy,
  output logic [DW-1:0] rdata
);
  logic pend_rd;
  logic wr_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rd <= 1'b0;
      wr_ack  <= 1'b0;
      trdy    <= 1'b0;
      rdata   <= '0;
    end else begin
      wr_ack <= start_vld && start_wr;
      trdy   <= wr_ack || (pend_rd && rsp_valid);
      if (start_vld && !start_wr)
        pend_rd <= 1'b1;
      else if (rsp_valid)
        pend_rd <= 1'b0;
      if (pend_rd && rsp_valid)
        rdata <= rsp_data;
    end
  end

  // R10: a read response taken while pending completes the data phase
  a_r10_rd_done: assert property (@(posedge clk) disable iff (rst)
    (pend_rd && rsp_valid) |=> (trdy && rdata == $past(rsp_data)));

endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate
  import pwx_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int BEW = DW / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic [AW-1:0]      ap_addr,
  input  logic [3:0]         ap_cmd,
  input  logic [BEW-1:0]     ap_be,
  input  logic [DW-1:0]      ap_wdata,
  input  logic [NWIN-1:0]    win_en,
  input  logic [NWIN*AW-1:0] win_base,
  input  logic [NWIN*AW-1:0] win_mask,
  input  logic [NWIN*AW-1:0] win_xlat,
  output logic               devsel,
  output logic               req_valid,
  output logic [AW-1:0]      req_addr,
  output logic               req_write,
  output logic               req_priv,
  output logic [BEW-1:0]     req_be,
  output logic [DW-1:0]      req_wdata,
  input  logic               rsp_valid,
  input  logic [DW-1:0]      rsp_data,
  output logic               trdy,
  output logic [DW-1:0]      pci_rdata
);

  logic [NWIN-1:0] win_hit;
  logic [NWIN-1:0] pick_grant;
  logic            pick_any;
  logic [AW-1:0]   win_xaddr [NWIN];
  logic [AW-1:0]   sel_addr;

  // one comparator/translator per window
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    pwx_win_cmp #(.AW(AW)) u_cmp (
      .en    (win_en[g]),
      .addr  (ap_addr),
      .base  (win_base[g*AW +: AW]),
      .mask  (win_mask[g*AW +: AW]),
      .xlat  (win_xlat[g*AW +: AW]),
      .hit   (win_hit[g]),
      .xaddr (win_xaddr[g])
    );
  end

  pwx_prio_pick #(.N(NWIN)) u_pick (
    .hit   (win_hit),
    .grant (pick_grant),
    .any   (pick_any)
  );

  always_comb begin
    sel_addr = '0;
    for (int i = 0; i < NWIN; i++)
      if (pick_grant[i]) sel_addr = sel_addr | win_xaddr[i];
  end

  // stage 1: decode result of the address phase
  logic           s1_vld;
  logic           s1_wr;
  logic [AW-1:0]  s1_addr;
  logic [BEW-1:0] s1_be;
  logic [DW-1:0]  s1_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_be    <= '0;
      s1_wdata <= '0;
    end else begin
      s1_vld <= frame_start && cmd_is_mem(ap_cmd) && pick_any;
      if (frame_start) begin
        s1_wr    <= cmd_is_wr(ap_cmd);
        s1_addr  <= sel_addr;
        s1_be    <= ap_be;
        s1_wdata <= ap_wdata;
      end
    end
  end

  // stage 2: device select and internal request, medium timing
  always_ff @(posedge clk) begin
    if (rst) begin
      devsel    <= 1'b0;
      req_valid <= 1'b0;
      req_priv  <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_be    <= '0;
      req_wdata <= '0;
    end else begin
      devsel    <= s1_vld;
      req_valid <= s1_vld && (!s1_wr || (s1_be != '0));
      req_priv  <= s1_vld && (!s1_wr || (s1_be != '0));
      if (s1_vld) begin
        req_write <= s1_wr;
        req_addr  <= s1_addr;
        req_be    <= s1_be;
        req_wdata <= s1_wdata;
      end
    end
  end

  pwx_rsp_path #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .start_vld (s1_vld),
    .start_wr  (s1_wr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .trdy      (trdy),
    .rdata     (pci_rdata)
  );

  // R4: device select only two edges after an address phase
  a_r4_devsel_timing: assert property (@(posedge clk) disable iff (rst)
    devsel |-> $past(frame_start, 2));

  // R3: only memory commands are ever claimed
  a_r3_mem_only: assert property (@(posedge clk) disable iff (rst)
    devsel |-> cmd_is_mem($past(ap_cmd, 2)));

  // R2: no enabled window means no claim
  a_r2_all_off: assert property (@(posedge clk) disable iff (rst)
    (frame_start && win_en == '0) |-> ##2 !devsel);

  // R8: an internal write always carries at least one lane
  a_r8_no_empty_wr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> (req_be != '0));

  // R7: direction follows command bit 0 of the claimed phase
  a_r7_dir: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_write == $past(ap_cmd[0], 2)));

  // R6: at most one window granted, and never above a lower hit
  a_r6_lowest: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_grant) && (((pick_grant - 1'b1) & win_hit) == '0));

endmodule

// File: tb/tb_pci_win_xlate.sv
module tb_pci_win_xlate;
  localparam int NWIN = 6;
  localparam int AW   = 32;
  localparam int DW   = 32;

  logic clk = 1'b0;
  logic rst;
  logic frame_start;
  logic [AW-1:0] ap_addr;
  logic [3:0] ap_cmd;
  logic [3:0] ap_be;
  logic [DW-1:0] ap_wdata;
  logic [NWIN-1:0] win_en;
  logic [NWIN*AW-1:0] win_base, win_mask, win_xlat;
  logic devsel, req_valid, req_write, req_priv, trdy;
  logic [AW-1:0] req_addr;
  logic [3:0] req_be;
  logic [DW-1:0] req_wdata, pci_rdata;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;

  int total = 0;
  int bad = 0;
  logic [31:0] mem [logic [31:0]];

  always #10 clk = ~clk;

  pci_win_xlate #(.NWIN(NWIN), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .ap_addr(ap_addr),
    .ap_cmd(ap_cmd), .ap_be(ap_be), .ap_wdata(ap_wdata), .win_en(win_en),
    .win_base(win_base), .win_mask(win_mask), .win_xlat(win_xlat),
    .devsel(devsel), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_priv(req_priv), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .trdy(trdy), .pci_rdata(pci_rdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hA5A5_0000;
  endfunction

  // behavioural reference: window walk in index order
  task automatic model(input logic [31:0] a, input logic [3:0] c,
                       output bit claim, output logic [31:0] xa);
    bit memcmd;
    claim = 0;
    xa = '0;
    memcmd = (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
    for (int i = 0; i < NWIN; i++) begin
      logic [31:0] m, b, x;
      m = win_mask[i*32 +: 32];
      b = win_base[i*32 +: 32];
      x = win_xlat[i*32 +: 32];
      if (!claim && win_en[i] && ((a & m) == (b & m))) begin
        claim = memcmd;
        xa = (x & m) | (a & ~m);
        if (!memcmd) break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R4", "idle devsel", {31'd0, devsel}, 32'd0);
      chk("R10", "idle trdy", {31'd0, trdy}, 32'd0);
      chk("R7", "idle req_valid", {31'd0, req_valid}, 32'd0);
    end
  endtask

  task automatic run_txn(input logic [31:0] a, input logic [3:0] c,
                         input logic [3:0] be, input logic [31:0] wd,
                         input string tag);
    bit claim, wr, req;
    logic [31:0] xa, exp_rd;
    model(a, c, claim, xa);
    wr = c[0];
    req = claim && (!wr || be != 4'h0);
    exp_rd = mem_rd(xa);
    @(negedge clk);
    frame_start = 1'b1; ap_addr = a; ap_cmd = c; ap_be = be; ap_wdata = wd;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R4", {tag, " devsel early"}, {31'd0, devsel}, 32'd0);
    chk("R4", {tag, " req early"}, {31'd0, req_valid}, 32'd0);
    @(negedge clk);
    chk(claim ? "R4" : tag, {tag, " devsel"}, {31'd0, devsel}, {31'd0, claim});
    chk((claim && wr && be == 0) ? "R8" : tag, {tag, " req_valid"},
        {31'd0, req_valid}, {31'd0, req});
    if (req) begin
      chk("R5", {tag, " req_addr"}, req_addr, xa);
      chk("R7", {tag, " req_priv"}, {31'd0, req_priv}, 32'd1);
      chk("R7", {tag, " req_write"}, {31'd0, req_write}, {31'd0, wr});
      chk("R7", {tag, " req_be"}, {28'd0, req_be}, {28'd0, be});
      if (wr) begin
        chk("R7", {tag, " req_wdata"}, req_wdata, wd);
        for (int l = 0; l < 4; l++)
          if (req_be[l]) begin
            logic [31:0] v;
            v = mem_rd(req_addr);
            v[l*8 +: 8] = req_wdata[l*8 +: 8];
            mem[req_addr] = v;
          end
      end
    end
    if (req_valid && !req_write) begin
      rsp_valid = 1'b1;
      rsp_data = mem_rd(req_addr);
    end
    @(negedge clk);
    rsp_valid = 1'b0;
    chk("R4", {tag, " devsel drop"}, {31'd0, devsel}, 32'd0);
    chk("R10", {tag, " trdy"}, {31'd0, trdy}, {31'd0, claim});
    if (claim && !wr)
      chk((be == 0) ? "R9" : "R10", {tag, " rdata"}, pci_rdata, exp_rd);
    @(negedge clk);
    chk("R10", {tag, " trdy drop"}, {31'd0, trdy}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; frame_start = 1'b0; ap_addr = '0; ap_cmd = '0; ap_be = '0;
    ap_wdata = '0; rsp_valid = 1'b0; rsp_data = '0;
    win_en = 6'b110111;
    win_base = '0; win_mask = '0; win_xlat = '0;
    win_base[0*32 +: 32] = 32'h1000_0000; win_mask[0*32 +: 32] = 32'hFFF0_0000; win_xlat[0*32 +: 32] = 32'h4000_0000;
    win_base[1*32 +: 32] = 32'h1000_0000; win_mask[1*32 +: 32] = 32'hFF00_0000; win_xlat[1*32 +: 32] = 32'h5000_0000;
    win_base[2*32 +: 32] = 32'h2000_0000; win_mask[2*32 +: 32] = 32'hFFFF_F000; win_xlat[2*32 +: 32] = 32'h6000_3FFF;
    win_base[3*32 +: 32] = 32'h3000_0000; win_mask[3*32 +: 32] = 32'hFFF0_0000; win_xlat[3*32 +: 32] = 32'h7000_0000;
    win_base[4*32 +: 32] = 32'hA000_0000; win_mask[4*32 +: 32] = 32'hFFFF_0000; win_xlat[4*32 +: 32] = 32'h0800_0000;
    win_base[5*32 +: 32] = 32'hB000_0000; win_mask[5*32 +: 32] = 32'hFFFF_0000; win_xlat[5*32 +: 32] = 32'h0900_0000;
    repeat (3) @(negedge clk);
    chk("R11", "reset devsel", {31'd0, devsel}, 32'd0);
    chk("R11", "reset req_valid", {31'd0, req_valid}, 32'd0);
    chk("R11", "reset req_priv", {31'd0, req_priv}, 32'd0);
    chk("R11", "reset trdy", {31'd0, trdy}, 32'd0);
    rst = 1'b0;
    idle(2);

    run_txn(32'h1000_1234, 4'h6, 4'hF, 0, "R6");            // W0 over W1
    run_txn(32'h1000_1234, 4'h7, 4'h3, 32'hDEAD_BEEF, "R7"); // partial write
    run_txn(32'h1000_1234, 4'h6, 4'hF, 0, "R10");           // merged readback
    run_txn(32'h1050_0010, 4'h6, 4'hF, 0, "R1");            // W1 only
    run_txn(32'h2000_0ABC, 4'hC, 4'hF, 0, "R5");            // low xlat bits masked
    run_txn(32'hA000_0040, 4'hF, 4'hC, 32'h1234_5678, "R7");
    run_txn(32'hB000_0080, 4'hE, 4'h1, 0, "R10");
    run_txn(32'h3000_0004, 4'h6, 4'hF, 0, "R1");            // disabled window
    run_txn(32'h7000_0000, 4'h6, 4'hF, 0, "R1");            // miss
    run_txn(32'h1000_1234, 4'h2, 4'hF, 0, "R3");
    run_txn(32'h1000_1234, 4'h3, 4'hF, 32'h1111_1111, "R3");
    run_txn(32'h1000_1234, 4'hA, 4'hF, 0, "R3");
    run_txn(32'h1000_1234, 4'hD, 4'hF, 0, "R3");
    run_txn(32'h2000_0010, 4'h7, 4'h0, 32'hFFFF_FFFF, "R8"); // empty write
    run_txn(32'h2000_0010, 4'h6, 4'hF, 0, "R8");            // unchanged
    run_txn(32'h1000_1234, 4'h6, 4'h0, 0, "R9");            // empty read
    win_en = '0;
    run_txn(32'h1000_1234, 4'h6, 4'hF, 0, "R2");
    run_txn(32'hA000_0040, 4'h7, 4'hF, 32'h5555_5555, "R2");
    win_en = 6'b110111;
    run_txn(32'hA000_0040, 4'h6, 4'hF, 0, "R2");            // R2 write had no effect
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule